// File: doc/BRIEF.md
# Secure Register Remap Unit

This unit lets code without privilege reach a selected set of registers that sit inside a protected address range. It does so through numbered remap channels: an access names a channel rather than an address, and the unit replaces the channel number with a target address that trusted software has programmed in advance. A configuration port holds the per-channel target addresses, a 64-bit channel enable vector split across two 32-bit words, a control word (operating mode, error-response suppression, interrupt enables), an unlock register, an unlock window length and a status word with write-one-to-clear error flags.

In open mode, any enabled channel can be used freely. In locked mode, a channel must first be unlocked by a keyed write. A successful unlock allows exactly one access to that channel within a programmable number of cycles, and the channel then relocks. If an access is refused, nothing is forwarded. The refusal is recorded in a flag, and the access port returns an error unless that response has been switched off. An unlock attempt is refused while any error flag is pending.

The access port is valid/ready. A request is taken on a cycle where `acc_valid` and `acc_ready` are both high. `acc_ready` stays low from acceptance until the forwarded transfer has completed, which is how back-pressure from the master side reaches the requester. The response is a one-cycle pulse on `rsp_valid` and cannot be stalled. The master port is a request/ready pair. `m_req` stays high with stable address and data until a cycle in which `m_ready` is high.

Top module: `sec_remap_unit`

## Requirements
- R1: Each channel n has its own target address register at configuration address 0x80+n, and a forwarded access to channel n drives that value on `m_addr`.
- R2: Channel enables are two 32-bit words: address 0x01 holds channels 0–31 (bit i = channel i) and address 0x02 holds channels 32–63 (bit i = channel 32+i). An access to a channel whose enable bit is clear is refused.
- R3: Control word (address 0x00) bit 0 selects the mode: 0 = open, 1 = locked. In open mode, an enabled channel is forwarded without any unlock. In locked mode, an enabled channel without a live grant is refused.
- R4: A write to the unlock register (address 0x03) carrying the key 0xA5 in bits 31:24 and a channel number below 64 in bits 5:0 creates a grant for that channel, provided no error flag is set.
- R5: A refused access is not forwarded (`m_req` stays low). It produces a `rsp_valid` pulse in the cycle after acceptance and sets status bit 0 (access-refused) at that same edge.
- R6: An unlock write made while any status error flag is set, or made with a wrong key or an out-of-range channel, creates no grant and sets status bit 1 (unlock-error).
- R7: Writing the clear register (address 0x05) with bit k = 1 clears status error flag k. Writing a 0 bit leaves that flag unchanged.
- R8: When control bit 1 is 1, a refused access answers with `rsp_err` = 0 while still setting status bit 0. When control bit 1 is 0, the refusal answers with `rsp_err` = 1.
- R9: Status bit 2 (idle) reads 1 when no forwarded transfer is in progress and 0 from the edge that accepts a forwarded access until the edge that completes it. `acc_ready` follows the same timing.
- R10: `irq` is high when (status bit 0 and control bit 2) or (status bit 1 and control bit 3).
- R11: A grant lasts for the number of cycles held in the window register (address 0x06). With the unlock write taken at edge e0, an access accepted at edges e0+1 to e0+W is permitted, and one access uses the grant up. A second access, or an access after the window, is refused.
- R12: A forwarded access holds `m_req`, `m_addr`, `m_write` and `m_wdata` stable until `m_ready` is high. `rsp_valid` then pulses in the following cycle with `rsp_err` = 0, and for a read `rsp_rdata` carries `m_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data, combinational on `cfg_addr` |
| acc_valid | input | 1 | Access request valid |
| acc_ready | output | 1 | Access request ready |
| acc_write | input | 1 | Access is a write |
| acc_chan | input | 6 | Channel number of the access |
| acc_wdata | input | 32 | Access write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 32 | Response read data |
| rsp_err | output | 1 | Response carries an error |
| m_req | output | 1 | Master request |
| m_ready | input | 1 | Master accepts and completes the request |
| m_write | output | 1 | Master request is a write |
| m_addr | output | 32 | Master address (channel target) |
| m_wdata | output | 32 | Master write data |
| m_rdata | input | 32 | Master read data, valid while `m_ready` is high |
| irq | output | 1 | Interrupt request |

## Verification
Status flags, the idle bit and `irq` change at the edge that follows the stimulus. The bench therefore updates its behavioural model when it drives a stimulus and compares `irq` against that model 5 ns after every rising edge. A refused access shows its `rsp_valid` at the first falling edge after acceptance. A forwarded access shows `m_req` at that same falling edge and `rsp_valid` one cycle after the cycle in which `m_ready` was high, and each check samples at exactly that falling edge. Grant windows are exercised at the last permitted cycle and at the first expired cycle, counting edges from the edge that takes the unlock write.

// File: rtl/srr_pkg.sv
package srr_pkg;
  localparam logic [7:0] A_CTRL     = 8'h00;
  localparam logic [7:0] A_EN_LO    = 8'h01;
  localparam logic [7:0] A_EN_HI    = 8'h02;
  localparam logic [7:0] A_UNLOCK   = 8'h03;
  localparam logic [7:0] A_STATUS   = 8'h04;
  localparam logic [7:0] A_CLEAR    = 8'h05;
  localparam logic [7:0] A_WINDOW   = 8'h06;
  localparam logic [7:0] A_TGT_BASE = 8'h80;

  // bit 0 = locked, bit 1 = error response off, bit 2/3 = irq enables
  typedef struct packed {
    logic ie_unl;
    logic ie_acc;
    logic berr_off;
    logic locked;
  } ctrl_t;

  typedef enum logic {FWD_IDLE = 1'b0, FWD_BUSY = 1'b1} fwd_state_t;
endpackage

// File: rtl/srr_cfg_regs.sv
module srr_cfg_regs
  import srr_pkg::*;
#(
  parameter int NCH  = 64,
  parameter int AW   = 32,
  parameter int WINW = 16,
  localparam int CHW = $clog2(NCH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [7:0]               cfg_addr,
  input  logic [31:0]              cfg_wdata,
  output logic [31:0]              cfg_rdata,
  input  logic                     idle,
  input  logic                     acc_fail_set,
  input  logic                     unl_err_set,
  output ctrl_t                    ctrl,
  output logic [NCH-1:0]           en_vec,
  output logic [NCH-1:0][AW-1:0]   tgt,
  output logic [WINW-1:0]          window,
  output logic [1:0]               flags,
  output logic                     irq,
  output logic                     unlock_wr
);
  logic [31:0] en_lo, en_hi;
  logic [63:0] en_full;
  logic        af, ue;
  logic        tgt_hit;
  logic [CHW-1:0] tgt_idx;
  logic        clr_wr;

  assign en_full   = {en_hi, en_lo};
  assign en_vec    = en_full[NCH-1:0];
  assign unlock_wr = cfg_we && (cfg_addr == A_UNLOCK);
  assign clr_wr    = cfg_we && (cfg_addr == A_CLEAR);
  assign tgt_idx   = cfg_addr[CHW-1:0];
  assign tgt_hit   = cfg_addr[7] && (int'(cfg_addr[6:0]) < NCH);
  assign flags     = {ue, af};
  assign irq       = (af && ctrl.ie_acc) || (ue && ctrl.ie_unl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      en_lo  <= '0;
      en_hi  <= '0;
      window <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        A_CTRL:   ctrl   <= ctrl_t'(cfg_wdata[3:0]);
        A_EN_LO:  en_lo  <= cfg_wdata;
        A_EN_HI:  en_hi  <= cfg_wdata;
        A_WINDOW: window <= cfg_wdata[WINW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) tgt[i] <= '0;
    end else if (cfg_we && tgt_hit) begin
      tgt[tgt_idx] <= cfg_wdata[AW-1:0];
    end
  end

  // error flags: a set in the same cycle as a clear wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      af <= 1'b0;
      ue <= 1'b0;
    end else begin
      af <= (af && !(clr_wr && cfg_wdata[0])) || acc_fail_set;
      ue <= (ue && !(clr_wr && cfg_wdata[1])) || unl_err_set;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (tgt_hit) begin
      cfg_rdata = 32'(tgt[tgt_idx]);
    end else begin
      case (cfg_addr)
        A_CTRL:   cfg_rdata = 32'(ctrl);
        A_EN_LO:  cfg_rdata = en_lo;
        A_EN_HI:  cfg_rdata = en_hi;
        A_STATUS: cfg_rdata = {29'd0, idle, ue, af};
        A_WINDOW: cfg_rdata = 32'(window);
        default:  cfg_rdata = '0;
      endcase
    end
  end

  AST_CLEAR_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr && (cfg_wdata[1:0] == 2'b00) && !acc_fail_set && !unl_err_set |=> $stable(flags)); // R7
  AST_FAIL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fail_set |=> flags[0]); // R5
endmodule

// File: rtl/srr_gate.sv
module srr_gate #(
  parameter int NCH  = 64,
  parameter int WINW = 16,
  parameter logic [7:0] KEY = 8'hA5,
  localparam int CHW = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            unlock_wr,
  input  logic [7:0]      unlock_key,
  input  logic [5:0]      unlock_chan,
  input  logic            flags_pending,
  input  logic [WINW-1:0] window,
  input  logic            grant_use,
  output logic            grant_valid,
  output logic [CHW-1:0]  grant_chan,
  output logic            unl_err_set
);
  logic [WINW-1:0] cnt;
  logic            key_ok, chan_ok, load;

  assign key_ok      = (unlock_key == KEY);
  assign chan_ok     = (int'(unlock_chan) < NCH);
  assign unl_err_set = unlock_wr && (flags_pending || !key_ok || !chan_ok);
  assign load        = unlock_wr && !unl_err_set;
  assign grant_valid = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      grant_chan <= '0;
    end else if (load) begin
      cnt        <= window;
      grant_chan <= unlock_chan[CHW-1:0];
    end else if (grant_use) begin
      cnt <= '0;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  AST_GRANT_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    grant_use && !load |=> !grant_valid); // R11
  AST_REFUSED_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_wr && flags_pending && !grant_valid |=> !grant_valid); // R6
endmodule

// File: rtl/srr_fwd.sv
module srr_fwd
  import srr_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [DW-1:0] acc_wdata,
  input  logic          allow,
  input  logic [AW-1:0] tgt_addr,
  input  logic          berr_off,
  output logic          acc_ready,
  output logic          accept,
  output logic          idle,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_err,
  output logic          m_req,
  input  logic          m_ready,
  output logic          m_write,
  output logic [AW-1:0] m_addr,
  output logic [DW-1:0] m_wdata,
  input  logic [DW-1:0] m_rdata
);
  fwd_state_t state;

  assign acc_ready = (state == FWD_IDLE);
  assign idle      = (state == FWD_IDLE);
  assign m_req     = (state == FWD_BUSY);
  assign accept    = acc_valid && acc_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= FWD_IDLE;
      m_write   <= 1'b0;
      m_addr    <= '0;
      m_wdata   <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      case (state)
        FWD_IDLE: begin
          if (accept) begin
            if (allow) begin
              state   <= FWD_BUSY;
              m_write <= acc_write;
              m_addr  <= tgt_addr;
              m_wdata <= acc_wdata;
            end else begin
              rsp_valid <= 1'b1;
              rsp_err   <= !berr_off;
              rsp_rdata <= '0;
            end
          end
        end
        FWD_BUSY: begin
          if (m_ready) begin
            state     <= FWD_IDLE;
            rsp_valid <= 1'b1;
            rsp_rdata <= m_write ? '0 : m_rdata;
          end
        end
        default: state <= FWD_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    m_req && !m_ready |=> m_req && $stable(m_addr) && $stable(m_wdata) && $stable(m_write)); // R12
  AST_RSP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    m_req && m_ready |=> rsp_valid && !rsp_err); // R12
  AST_BUSY_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept && allow |=> !idle && !acc_ready); // R9
endmodule

// File: rtl/sec_remap_unit.sv
module sec_remap_unit
  import srr_pkg::*;
#(
  parameter int NCH  = 64,
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int WINW = 16,
  parameter logic [7:0] UNLOCK_KEY = 8'hA5,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [7:0]     cfg_addr,
  input  logic [31:0]    cfg_wdata,
  output logic [31:0]    cfg_rdata,
  input  logic           acc_valid,
  output logic           acc_ready,
  input  logic           acc_write,
  input  logic [CHW-1:0] acc_chan,
  input  logic [DW-1:0]  acc_wdata,
  output logic           rsp_valid,
  output logic [DW-1:0]  rsp_rdata,
  output logic           rsp_err,
  output logic           m_req,
  input  logic           m_ready,
  output logic           m_write,
  output logic [AW-1:0]  m_addr,
  output logic [DW-1:0]  m_wdata,
  input  logic [DW-1:0]  m_rdata,
  output logic           irq
);
  ctrl_t                  ctrl;
  logic [NCH-1:0]         en_vec;
  logic [NCH-1:0][AW-1:0] tgt;
  logic [WINW-1:0]        window;
  logic [1:0]             flags;
  logic                   unlock_wr, unl_err_set;
  logic                   grant_valid, grant_use;
  logic [CHW-1:0]         grant_chan;
  logic                   idle, accept, allow, acc_fail_set;

  always_comb begin
    allow = en_vec[acc_chan] &&
            (!ctrl.locked || (grant_valid && (grant_chan == acc_chan)));
  end
  assign acc_fail_set = accept && !allow;
  assign grant_use    = accept && allow && ctrl.locked;

  srr_cfg_regs #(.NCH(NCH), .AW(AW), .WINW(WINW)) u_regs (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .idle, .acc_fail_set, .unl_err_set,
    .ctrl, .en_vec, .tgt, .window, .flags, .irq, .unlock_wr
  );

  srr_gate #(.NCH(NCH), .WINW(WINW), .KEY(UNLOCK_KEY)) u_gate (
    .clk, .rst_n, .unlock_wr,
    .unlock_key(cfg_wdata[31:24]), .unlock_chan(cfg_wdata[5:0]),
    .flags_pending(|flags), .window, .grant_use,
    .grant_valid, .grant_chan, .unl_err_set
  );

  srr_fwd #(.AW(AW), .DW(DW)) u_fwd (
    .clk, .rst_n, .acc_valid, .acc_write, .acc_wdata,
    .allow, .tgt_addr(tgt[acc_chan]), .berr_off(ctrl.berr_off),
    .acc_ready, .accept, .idle,
    .rsp_valid, .rsp_rdata, .rsp_err,
    .m_req, .m_ready, .m_write, .m_addr, .m_wdata, .m_rdata
  );

  AST_DENY_NOT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_ready && !allow |=> !m_req && rsp_valid); // R5
  AST_PENDING_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_wr && (|flags) |=> flags[1]); // R6
endmodule

// File: tb/sec_remap_unit_tb.sv
module sec_remap_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic        acc_ready;
  logic [5:0]  acc_chan = '0;
  logic [31:0] acc_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic        m_req, m_write;
  logic        m_ready = 1'b0;
  logic [31:0] m_addr, m_wdata;
  logic [31:0] m_rdata = '0;
  logic        irq;

  int checks = 0, fails = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;
  // behavioural model
  bit mdl_af = 0, mdl_ue = 0, mdl_ie_a = 0, mdl_ie_u = 0;

  always #10 clk = ~clk;

  sec_remap_unit u_dut (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .acc_valid, .acc_ready, .acc_write, .acc_chan, .acc_wdata,
    .rsp_valid, .rsp_rdata, .rsp_err,
    .m_req, .m_ready, .m_write, .m_addr, .m_wdata, .m_rdata, .irq
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // R10: irq compared to the model after every rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (cmp_on) chk("R10 irq", 32'(irq), 32'((mdl_af & mdl_ie_a) | (mdl_ue & mdl_ie_u)));
    end
  end

  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    if (a == 8'h00) begin mdl_ie_a = d[2]; mdl_ie_u = d[3]; end
    if (a == 8'h05) begin
      if (d[0]) mdl_af = 0;
      if (d[1]) mdl_ue = 0;
    end
    if (a == 8'h03) begin
      if (mdl_af || mdl_ue || d[31:24] != 8'hA5) mdl_ue = 1;
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [7:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic access(input string req, input bit wr, input logic [5:0] ch,
                        input logic [31:0] wd, input bit exp_allow,
                        input logic [31:0] exp_addr, input bit exp_err,
                        input logic [31:0] mrd);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_chan = ch; acc_wdata = wd;
    m_ready = 1'b1; m_rdata = mrd;
    if (!exp_allow) mdl_af = 1;
    @(negedge clk);
    acc_valid = 1'b0;
    if (exp_allow) begin
      chk({req, " m_req"}, 32'(m_req), 32'd1);
      chk({req, " m_addr"}, m_addr, exp_addr);
      chk({req, " m_write"}, 32'(m_write), 32'(wr));
      if (wr) chk({req, " m_wdata"}, m_wdata, wd);
      @(negedge clk);
      chk({req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
      chk({req, " rsp_err"}, 32'(rsp_err), 32'd0);
      if (!wr) chk({req, " rsp_rdata"}, rsp_rdata, mrd);
      chk({req, " m_req done"}, 32'(m_req), 32'd0);
    end else begin
      chk({req, " refused m_req"}, 32'(m_req), 32'd0);
      chk({req, " refused rsp_valid"}, 32'(rsp_valid), 32'd1);
      chk({req, " refused rsp_err"}, 32'(rsp_err), 32'(exp_err));
    end
    m_ready = 1'b0;
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    @(negedge clk);

    // reset state (R9: idle after reset)
    cfg_read(8'h04, rd);
    chk("R9 reset status", rd, 32'h4);
    chk("R9 reset acc_ready", 32'(acc_ready), 32'd1);
    chk("R12 reset m_req", 32'(m_req), 32'd0);
    chk("R5 reset rsp_valid", 32'(rsp_valid), 32'd0);

    // R1/R2: targets and enables
    cfg_write(8'h83, 32'h4000_0010);
    cfg_write(8'hA8, 32'h4000_2200);
    cfg_write(8'h01, 32'h0000_0008);
    cfg_write(8'h02, 32'h0000_0100);
    cfg_read(8'hA8, rd);
    chk("R1 target readback", rd, 32'h4000_2200);
    cfg_read(8'h02, rd);
    chk("R2 enable high readback", rd, 32'h0000_0100);

    // R3 open mode, R1 forwarding, R2 low and high halves
    access("R1 open write ch3", 1'b1, 6'd3, 32'hDEAD_BEEF, 1'b1, 32'h4000_0010, 1'b0, 32'h0);
    access("R2 open read ch40", 1'b0, 6'd40, 32'h0, 1'b1, 32'h4000_2200, 1'b0, 32'h1234_5678);

    // R5 disabled channel refused
    access("R5 disabled ch5", 1'b1, 6'd5, 32'h1, 1'b0, 32'h0, 1'b1, 32'h0);
    cfg_read(8'h04, rd);
    chk("R5 access-refused flag", rd, 32'h5);

    // R7 write-one-to-clear, R10 irq enable
    cfg_write(8'h00, 32'h4);
    chk("R10 irq on flag", 32'(irq), 32'd1);
    cfg_write(8'h05, 32'h0);
    cfg_read(8'h04, rd);
    chk("R7 zero write keeps flag", rd, 32'h5);
    cfg_write(8'h05, 32'h1);
    cfg_read(8'h04, rd);
    chk("R7 one write clears flag", rd, 32'h4);

    // R3 locked mode needs a grant
    cfg_write(8'h00, 32'h5);
    access("R3 locked no grant", 1'b1, 6'd3, 32'h2, 1'b0, 32'h0, 1'b1, 32'h0);
    chk("R10 irq locked refusal", 32'(irq), 32'd1);
    cfg_write(8'h05, 32'h1);

    // R4 / R11 one access per grant
    cfg_write(8'h06, 32'd4);
    cfg_write(8'h03, 32'hA500_0003);
    access("R4 granted ch3", 1'b1, 6'd3, 32'h55AA_0001, 1'b1, 32'h4000_0010, 1'b0, 32'h0);
    access("R11 second access", 1'b1, 6'd3, 32'h3, 1'b0, 32'h0, 1'b1, 32'h0);
    cfg_write(8'h05, 32'h1);

    // R11 grant for another channel does not cover ch3
    cfg_write(8'h03, 32'hA500_0028);
    access("R11 wrong channel", 1'b1, 6'd3, 32'h3, 1'b0, 32'h0, 1'b1, 32'h0);
    cfg_write(8'h05, 32'h1);

    // R11 window boundary: W=3, last permitted edge
    cfg_write(8'h06, 32'd3);
    cfg_write(8'h03, 32'hA500_0003);
    @(negedge clk);
    access("R11 last window cycle", 1'b0, 6'd3, 32'h0, 1'b1, 32'h4000_0010, 1'b0, 32'hCAFE_0003);
    // first expired edge
    cfg_write(8'h03, 32'hA500_0003);
    repeat (2) @(negedge clk);
    access("R11 window expired", 1'b0, 6'd3, 32'h0, 1'b0, 32'h0, 1'b1, 32'h0);
    cfg_write(8'h05, 32'h1);

    // R6 wrong key
    cfg_write(8'h03, 32'h5A00_0003);
    cfg_read(8'h04, rd);
    chk("R6 wrong key flag", rd, 32'h6);
    access("R6 no grant after bad key", 1'b1, 6'd3, 32'h0, 1'b0, 32'h0, 1'b1, 32'h0);
    cfg_write(8'h05, 32'h3);

    // R6 unlock refused while a flag is pending
    access("R6 make pending flag", 1'b1, 6'd3, 32'h0, 1'b0, 32'h0, 1'b1, 32'h0);
    cfg_write(8'h03, 32'hA500_0003);
    cfg_write(8'h05, 32'h1);
    cfg_read(8'h04, rd);
    chk("R6 pending unlock error flag", rd, 32'h6);
    access("R6 pending unlock no grant", 1'b1, 6'd3, 32'h0, 1'b0, 32'h0, 1'b1, 32'h0);
    cfg_write(8'h05, 32'h3);

    // R8 error response suppressed, flag still set
    cfg_write(8'h00, 32'h3);
    access("R8 suppressed error", 1'b1, 6'd9, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0);
    cfg_read(8'h04, rd);
    chk("R8 flag still set", rd, 32'h5);
    cfg_write(8'h05, 32'h1);

    // R10 unlock-error interrupt only
    cfg_write(8'h00, 32'h8);
    access("R10 refused with access irq off", 1'b1, 6'd9, 32'h0, 1'b0, 32'h0, 1'b1, 32'h0);
    chk("R10 irq masked", 32'(irq), 32'd0);
    cfg_write(8'h03, 32'h0000_0003);
    chk("R10 irq unlock error", 32'(irq), 32'd1);
    cfg_write(8'h05, 32'h3);
    chk("R10 irq cleared", 32'(irq), 32'd0);

    // R9 / R12 back-pressure from the master side
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_chan = 6'd3; m_ready = 1'b0;
    @(negedge clk);
    acc_valid = 1'b0;
    cfg_read(8'h04, rd);
    chk("R9 idle low while busy", rd, 32'h0);
    chk("R9 acc_ready low while busy", 32'(acc_ready), 32'd0);
    repeat (2) @(negedge clk);
    chk("R12 m_req held", 32'(m_req), 32'd1);
    chk("R12 m_addr held", m_addr, 32'h4000_0010);
    chk("R12 no early rsp", 32'(rsp_valid), 32'd0);
    m_ready = 1'b1; m_rdata = 32'h0BAD_F00D;
    @(negedge clk);
    m_ready = 1'b0;
    chk("R12 rsp after ready", 32'(rsp_valid), 32'd1);
    chk("R12 rsp data", rsp_rdata, 32'h0BAD_F00D);
    cfg_read(8'h04, rd);
    chk("R9 idle again", rd, 32'h4);

    repeat (2) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule